// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer with Distributed Refresh

This block sits between a simple word-request port and a 64K x 4 dynamic memory whose sixteen address bits travel in two halves over one shared 8-bit address bus. A host request carries a 16-bit word address, split into a row half in bits 15:8 and a column half in bits 7:0, plus a write flag and 4 bits of data. The block turns each request into the strobe sequence the memory expects. It first puts the row on the bus and drops the row strobe. After the row hold time it switches the bus to the column and drops the column strobe. For a read it captures the memory's output once the access time has passed.

After an access the row strobe stays low so that later requests to the same row need only a column strobe cycle. The page is closed when a different row is requested, when a refresh falls due, or when the row strobe has been low as long as the memory allows. A free-running interval timer schedules refresh. Each refresh presents the next row from an 8-bit counter and pulses only the row strobe, so that all 256 rows are covered within the retention window. All delays are given as clock-cycle parameters.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe and write strobe are all high, the data bus is not driven, no read result is flagged, and a request is accepted (`req_ready` high).
- R2: At the cycle the row strobe falls, `dram_addr` holds request bits 15:8. At the cycle the column strobe falls, it holds request bits 7:0. The column strobe falls at least `T_RCD` cycles after the row strobe and only while the row strobe is low.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` drives `req_wdata` at least one cycle before the column strobe falls. For a read, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R4: Every read produces exactly one `rd_valid` pulse, in request order. `rd_data` equals `dram_dq_in` after the column strobe has been low for `T_CAS` cycles, which is the last value written to that address.
- R5: A request to the row that is already open is served by a column strobe cycle alone, with no new row strobe fall.
- R6: A request to a different row closes the page. Between a rise and the next fall, the row strobe stays high for at least `T_RP` cycles.
- R7: A refresh falls due every `REF_INTERVAL` cycles. Each refresh holds the column strobe high for its whole row-strobe pulse, and on an idle bus successive refreshes start exactly `REF_INTERVAL` cycles apart.
- R8: The refreshed row starts at 0 and rises by one per refresh, wrapping from 255 to 0.
- R9: A pending refresh takes priority over requests: `req_ready` is low, the open page is closed, and refreshes keep their rate under continuous traffic.
- R10: The row strobe never stays low for more than `T_RAS_MAX` consecutive cycles.
- R11: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request gets exactly one column strobe cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | 2*ADDR_W | Word address, row in upper half, column in lower half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Data driven to memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by memory |

## Verification
The assertions assume a consistent timing configuration. `T_RAS_MAX` must be at least `T_RCD + T_CAS + 2`. `REF_INTERVAL` must exceed the worst wait for a refresh: one open-page access, one precharge and one refresh pulse. A second refresh tick must never find the first one still pending. The assertions also assume the host holds address, flag and data steady while `req_valid` is high and not yet accepted. The bench meets these assumptions in three ways. It picks `T_RAS_MAX` of 24 and an interval of 60 cycles against access paths of about a dozen cycles. It drives requests only at falling edges. It holds each request until it sees `req_ready` high.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROW_SET,
    S_RCD,
    S_COL_SET,
    S_CAS,
    S_OPEN,
    S_PRE,
    S_REF_SET,
    S_REF_RAS
  } seq_state_t;

  // bits needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int wait_max(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // last RAS-low count at which another column cycle may still start:
  // one setup cycle, T_CAS strobe cycles and one open cycle follow it
  function automatic int ras_open_limit(input int t_ras_max, input int t_cas);
    return t_ras_max - t_cas - 2;
  endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  output logic             pending_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = fpm_pkg::cnt_width(INTERVAL - 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0]    tcnt;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             tick;

  assign tick      = (tcnt == LAST);
  assign pending_o = pend_q;
  assign row_o     = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tcnt   <= tick ? '0 : tcnt + 1'b1;
      pend_q <= tick | (pend_q & ~done_i);
      if (done_i) row_q <= row_q + 1'b1;
    end
  end

  // R7
  no_lost_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!pend_q || done_i));

  // R9
  done_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> pend_q);

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (row_q == $past(row_q) + 1'b1));

endmodule

// File: rtl/dram_ras_guard.sv
module dram_ras_guard #(
  parameter int T_RAS_MAX = 500,
  parameter int T_CAS     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n_i,
  output logic expired_o
);
  localparam int GW = fpm_pkg::cnt_width(T_RAS_MAX);
  localparam logic [GW-1:0] LIMIT = GW'(fpm_pkg::ras_open_limit(T_RAS_MAX, T_CAS));
  localparam logic [GW-1:0] MAXV  = GW'(T_RAS_MAX);

  logic [GW-1:0] lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lcnt <= '0;
    else if (ras_n_i)     lcnt <= '0;
    else if (lcnt != MAXV) lcnt <= lcnt + 1'b1;
  end

  assign expired_o = (lcnt >= LIMIT);

  // R10
  ras_low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_i |-> (lcnt < MAXV));

endmodule

// File: rtl/dram_page_tag.sv
module dram_page_tag #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (load_i) row_q <= load_row_i;
  end

  assign hit_o = (cmp_row_i == row_q);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int T_RFP        = 4,
  parameter int T_RAS_MAX    = 500,
  parameter int REF_INTERVAL = 780
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2*ADDR_W-1:0]   req_addr,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W-1:0]     dram_addr,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic [DATA_W-1:0]     dram_dq_out,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_in
);
  import fpm_pkg::*;

  localparam int WC_W = cnt_width(wait_max(T_RCD, T_CAS, T_RP, T_RFP));
  localparam logic [WC_W-1:0] RCD_LD = WC_W'(T_RCD - 1);
  localparam logic [WC_W-1:0] CAS_LD = WC_W'(T_CAS - 1);
  localparam logic [WC_W-1:0] RP_LD  = WC_W'(T_RP - 1);
  localparam logic [WC_W-1:0] RFP_LD = WC_W'(T_RFP - 1);

  seq_state_t          st;
  logic [WC_W-1:0]     wait_cnt;
  logic                cur_write;
  logic [ADDR_W-1:0]   cur_col;
  logic [DATA_W-1:0]   cur_data;

  logic [ADDR_W-1:0]   req_row;
  logic [ADDR_W-1:0]   req_col;
  logic                ref_pending;
  logic [ADDR_W-1:0]   ref_row;
  logic                ras_expired;
  logic                page_hit;

  // named internal events
  logic accept;
  logic ref_done;
  logic page_close;
  logic in_refresh;
  logic wait_done;

  assign req_row    = req_addr[2*ADDR_W-1:ADDR_W];
  assign req_col    = req_addr[ADDR_W-1:0];
  assign wait_done  = (wait_cnt == '0);
  assign req_ready  = !ref_pending &&
                      ((st == S_IDLE) || (st == S_OPEN && !ras_expired && page_hit));
  assign accept     = req_valid && req_ready;
  assign ref_done   = (st == S_REF_RAS) && wait_done;
  assign page_close = (st == S_OPEN) &&
                      (ref_pending || ras_expired || (req_valid && !page_hit));
  assign in_refresh = (st == S_REF_SET) || (st == S_REF_RAS);

  dram_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ADDR_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (ref_done),
    .pending_o (ref_pending),
    .row_o     (ref_row)
  );

  dram_ras_guard #(.T_RAS_MAX(T_RAS_MAX), .T_CAS(T_CAS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n_i   (dram_ras_n),
    .expired_o (ras_expired)
  );

  dram_page_tag #(.ROW_W(ADDR_W)) u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept && st == S_IDLE),
    .load_row_i (req_row),
    .cmp_row_i  (req_row),
    .hit_o      (page_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      wait_cnt    <= '0;
      cur_write   <= 1'b0;
      cur_col     <= '0;
      cur_data    <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (ref_pending) begin
            dram_addr <= ref_row;
            st        <= S_REF_SET;
          end else if (accept) begin
            dram_addr <= req_row;
            cur_col   <= req_col;
            cur_write <= req_write;
            cur_data  <= req_wdata;
            st        <= S_ROW_SET;
          end
        end
        S_ROW_SET: begin
          dram_ras_n <= 1'b0;
          wait_cnt   <= RCD_LD;
          st         <= S_RCD;
        end
        S_RCD: begin
          if (wait_done) begin
            dram_addr   <= cur_col;
            dram_we_n   <= !cur_write;
            dram_dq_oe  <= cur_write;
            dram_dq_out <= cur_data;
            st          <= S_COL_SET;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        S_COL_SET: begin
          dram_cas_n <= 1'b0;
          wait_cnt   <= CAS_LD;
          st         <= S_CAS;
        end
        S_CAS: begin
          if (wait_done) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!cur_write) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            st <= S_OPEN;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        S_OPEN: begin
          if (page_close) begin
            dram_ras_n <= 1'b1;
            wait_cnt   <= RP_LD;
            st         <= S_PRE;
          end else if (accept) begin
            dram_addr   <= req_col;
            dram_we_n   <= !req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            cur_write   <= req_write;
            st          <= S_COL_SET;
          end
        end
        S_PRE: begin
          if (wait_done) st <= S_IDLE;
          else           wait_cnt <= wait_cnt - 1'b1;
        end
        S_REF_SET: begin
          dram_ras_n <= 1'b0;
          wait_cnt   <= RFP_LD;
          st         <= S_REF_RAS;
        end
        S_REF_RAS: begin
          if (wait_done) begin
            dram_ras_n <= 1'b1;
            wait_cnt   <= RP_LD;
            st         <= S_PRE;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !req_ready);

  // R9
  refresh_closes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && ref_pending) |=> dram_ras_n);

  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe));

  // R3
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && dram_we_n) |-> !dram_dq_oe);

  // R2
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  // R7
  refresh_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_refresh |-> dram_cas_n);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!dram_cas_n) && dram_cas_n));

endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RFP = 4;
  localparam int T_RAS_MAX = 24, REF_INTERVAL = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, rd_data, dram_dq_out, dram_dq_in;
  logic        rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [7:0]  dram_addr;

  fpm_dram_ctrl #(.ADDR_W(8), .DATA_W(4), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
                  .T_RFP(T_RFP), .T_RAS_MAX(T_RAS_MAX), .REF_INTERVAL(REF_INTERVAL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] idx(input logic [7:0] r, input logic [7:0] c);
    return {r[4:0], c[4:0]};
  endfunction

  // memory model and host shadow
  logic [3:0]  mem     [0:1023];
  logic [3:0]  exp_mem [0:1023];
  logic [15:0] afifo   [0:2047];
  logic [3:0]  rfifo   [0:2047];
  int a_wr = 0, a_rd = 0, r_wr = 0, r_rd = 0;

  logic [7:0] m_row = '0, m_col = '0;
  assign dram_dq_in = dram_cas_n ? 4'h0 : mem[idx(m_row, m_col)];

  int  cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = -100, low_len = 0;
  int  opens = 0, refreshes = 0, last_ref_fall = 0;
  int  pre_err = 0, len_err = 0, cas_err = 0, rcd_err = 0, addr_err = 0, we_err = 0;
  int  ref_err = 0, gap_err = 0;
  bit  prev_ras = 1, prev_cas = 1, prev_we = 1, cas_seen = 0, have_ref = 0, gap_mode = 0;
  logic [7:0] exp_ref_row = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (prev_ras && !dram_ras_n) begin
        m_row = dram_addr;
        cas_seen = 0;
        ras_fall_cyc = cyc;
        if (cyc - ras_rise_cyc < T_RP) pre_err++;
        low_len = 0;
      end
      if (!dram_ras_n) begin
        low_len++;
        if (low_len > T_RAS_MAX) len_err++;
      end
      if (prev_cas && !dram_cas_n) begin
        if (dram_ras_n) cas_err++;
        if (!cas_seen && (cyc - ras_fall_cyc < T_RCD)) rcd_err++;
        if (!cas_seen) opens++;
        cas_seen = 1;
        m_col = dram_addr;
        if ({m_row, dram_addr} != afifo[a_rd % 2048]) addr_err++;
        a_rd++;
        if (!dram_we_n) begin
          if (!dram_dq_oe || prev_we) we_err++;
          mem[idx(m_row, dram_addr)] = dram_dq_out;
        end else if (dram_dq_oe) we_err++;
      end
      if (!prev_ras && dram_ras_n) begin
        ras_rise_cyc = cyc;
        if (!cas_seen) begin
          if (m_row != exp_ref_row) ref_err++;
          exp_ref_row = exp_ref_row + 8'd1;
          if (gap_mode && have_ref && (ras_fall_cyc - last_ref_fall != REF_INTERVAL)) gap_err++;
          last_ref_fall = ras_fall_cyc;
          have_ref = 1;
          refreshes++;
        end
      end
      if (rd_valid) begin
        // R4 read data equals last written value, in order
        chk(rd_data == rfifo[r_rd % 2048], "R4 read data", rd_data, rfifo[r_rd % 2048]);
        r_rd++;
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_we  = dram_we_n;
    end
  end

  // R11 handshake: held until ready seen, taken at the next rising edge
  task automatic issue(input logic [7:0] row, input logic [7:0] col, input bit w,
                       input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {row, col}; req_write = w; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    afifo[a_wr % 2048] = {row, col}; a_wr++;
    if (w) exp_mem[idx(row, col)] = d;
    else begin
      rfifo[r_wr % 2048] = exp_mem[idx(row, col)];
      r_wr++;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic sync_refresh();
    int r0;
    r0 = refreshes;
    while (refreshes == r0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int o0, f0, c0;
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(dram_ras_n == 1'b1, "R1 ras_n", dram_ras_n, 1);
    chk(dram_cas_n == 1'b1, "R1 cas_n", dram_cas_n, 1);
    chk(dram_we_n == 1'b1,  "R1 we_n", dram_we_n, 1);
    chk(dram_dq_oe == 1'b0, "R1 dq_oe", dram_dq_oe, 0);
    chk(rd_valid == 1'b0,   "R1 rd_valid", rd_valid, 0);
    chk(req_ready == 1'b1,  "R1 ready", req_ready, 1);

    // sweep: row-major writes, column-major reads (R2 R3 R4)
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 8; c++)
        issue(8'(r), 8'(c * 3), 1'b1, 4'((r * 3 + c * 5 + 1) & 15));
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 32; r++)
        issue(8'(r), 8'(c * 3), 1'b0, 4'h0);
    // mixed write/read inside one row
    for (int i = 0; i < 16; i++) begin
      issue(8'd20, 8'(i + 1), 1'b1, 4'(15 - i));
      issue(8'd20, 8'(i + 1), 1'b0, 4'h0);
    end
    idle(40);

    // R5 page hits: one row open for three accesses
    sync_refresh();
    o0 = opens;
    issue(8'd7, 8'd0, 1'b1, 4'h9);
    issue(8'd7, 8'd1, 1'b1, 4'h6);
    issue(8'd7, 8'd0, 1'b0, 4'h0);
    idle(8);
    chk(opens - o0 == 1, "R5 page hit opens", opens - o0, 1);

    // R6 row misses reopen the page each time
    sync_refresh();
    o0 = opens;
    issue(8'd1, 8'd4, 1'b0, 4'h0);
    issue(8'd2, 8'd4, 1'b0, 4'h0);
    issue(8'd3, 8'd4, 1'b0, 4'h0);
    idle(8);
    chk(opens - o0 == 3, "R6 miss opens", opens - o0, 3);

    // R10 long same-row run forces a close
    sync_refresh();
    o0 = opens;
    for (int i = 0; i < 12; i++) issue(8'd9, 8'(i), 1'b1, 4'(i));
    idle(8);
    chk(opens - o0 >= 2, "R10 forced reopen", opens - o0, 2);

    // R9 refresh keeps its rate under continuous traffic
    f0 = refreshes; c0 = cyc;
    for (int i = 0; i < 100; i++)
      issue(8'(i % 4), 8'((i * 7) % 32), (i % 3) != 0, 4'((i * 7) & 15));
    chk((refreshes - f0) >= (cyc - c0) / REF_INTERVAL - 1, "R9 refresh under load",
        refreshes - f0, (cyc - c0) / REF_INTERVAL - 1);
    idle(40);

    // R7 R8 idle refresh spacing and row wrap
    gap_mode = 1; have_ref = 0;
    idle(265 * REF_INTERVAL);
    gap_mode = 0;
    chk(gap_err == 0, "R7 refresh spacing", gap_err, 0);
    chk(refreshes > 256, "R8 wrap reached", refreshes, 257);
    chk(ref_err == 0, "R8 refresh row order", ref_err, 0);

    chk(pre_err == 0, "R6 precharge", pre_err, 0);
    chk(len_err == 0, "R10 ras low time", len_err, 0);
    chk(cas_err == 0, "R2 cas outside ras", cas_err, 0);
    chk(rcd_err == 0, "R2 row to column delay", rcd_err, 0);
    chk(addr_err == 0, "R2 address mux", addr_err, 0);
    chk(we_err == 0, "R3 write strobe", we_err, 0);
    chk(a_rd == a_wr, "R11 one column cycle per request", a_rd, a_wr);
    chk(r_rd == r_wr, "R4 one result per read", r_rd, r_wr);

    finished = 1;
    summary();
    $finish;
  end

endmodule